// File: doc/BRIEF.md
# Asynchronous Bus Write Target

This block is a memory-side target on an asynchronous 32-bit bus with strobe and acknowledge handshaking. A master puts an address, a two-bit transfer size, a read/write level and write data on the bus, then drops an address strobe and a data strobe. The target synchronizes both strobes, checks that the upper address bits match its base, and works out from the size and the two low address bits which of the four byte lanes carry data. It writes those lanes into a small internal word array and then answers with a two-bit active-low acknowledge that tells the master the port is a full 32 bits wide.

A programmable delay before the acknowledge lets a test environment make the master insert wait states. The acknowledge then stays low for as long as both strobes are held. Once either strobe is released, the acknowledge is removed quickly, so it cannot be mistaken for the answer to the next transfer. A combinational peek port reads any stored word, so the stored contents can be seen from outside.

Top module: `async_wr_target`

## Requirements
- R1: While reset is active and after it is released, `dackN` is 2'b11 and every stored word reads as zero.
- R2: A write stores byte lanes selected by `siz` (01 one byte, 10 two bytes, 11 three bytes, 00 four bytes) starting at the lane given by `addr[1:0]`. Lane 0 is bits 31:24 and lane 3 is bits 7:0. The run of lanes is cut off after lane 3.
- R3: Lanes not selected by a write keep their earlier value. Each stored lane takes the same lane of `dataIn`.
- R4: On a qualifying write, `dackN` goes to 2'b00 after exactly `delayCfg`+4 rising edges, counted from the first edge that samples `dsN` low. `asN` is already low at that point.
- R5: `dackN` stays 2'b00 for as long as both strobes remain low.
- R6: Once either strobe goes high, `dackN` returns to 2'b11 at the third rising edge after that change.
- R7: A cycle with `rwN` high (read) gets no acknowledge and changes no stored word.
- R8: If a strobe is released before the acknowledge is given, nothing is stored and no acknowledge appears.
- R9: A cycle whose `addr` bits above the word index differ from `BASE_TAG` gets no acknowledge and changes no stored word.
- R10: `dackN` only ever takes the values 2'b11 and 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rstN | input | 1 | Asynchronous active-low reset |
| asN | input | 1 | Address strobe, active low, asynchronous |
| dsN | input | 1 | Data strobe, active low, asynchronous |
| rwN | input | 1 | High for read, low for write |
| siz | input | 2 | Transfer size code |
| addr | input | ADDR_W | Byte address: base tag, word index, lane offset |
| dataIn | input | 32 | Write data, all four lanes |
| delayCfg | input | DLY_W | Extra clocks before acknowledging |
| peekIdx | input | IDX_W | Word index for the peek port |
| peekData | output | 32 | Stored word at `peekIdx` |
| dackN | output | 2 | Acknowledge, active low, 2'b00 = 32-bit port |

## Verification
The bench builds the target with its defaults: an 8-bit address, four words, a 3-bit delay and base tag 4'hA. With four words, every index can be written several times, so partial writes are checked on top of earlier data. The 3-bit delay covers the full span from zero to seven wait clocks, and each value gets an exact latency check. The short address makes it easy to pick a mismatching tag and every lane offset, including the offsets where three-byte and four-byte transfers are cut off at lane 3.

// File: rtl/async_wr_pkg.sv
package async_wr_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } tgtState_t;

  // control to datapath strobes
  typedef struct packed {
    logic capture;  // latch index and lane mask
    logic commit;   // write latched lanes from dataIn
  } ctrlStrobes_t;

  // mask bit (LANES-1-k) enables lane k; lane 0 is the top byte
  function automatic logic [LANES-1:0] laneMask(input logic [1:0] sizCode,
                                                input logic [1:0] offset);
    logic [LANES-1:0] m;
    int count;
    count = (sizCode == 2'b00) ? LANES : int'(sizCode);
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k >= int'(offset) && k < int'(offset) + count)
        m[LANES-1-k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/async_wr_sync.sv
module async_wr_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= INIT;
      syncOut <= INIT;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/async_wr_ctrl.sv
module async_wr_ctrl
  import async_wr_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             asOn,
  input  logic             dsOn,
  input  logic             rwN,
  input  logic             addrHit,
  input  logic [DLY_W-1:0] delayCfg,
  output ctrlStrobes_t     strobes,
  output logic [1:0]       dackN
);

  tgtState_t        state, stateNxt;
  logic [DLY_W-1:0] cnt, cntNxt;
  logic             bothOn;

  assign bothOn = asOn && dsOn;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strobes  = '0;
    unique case (state)
      ST_IDLE: begin
        if (bothOn && !rwN && addrHit) begin
          strobes.capture = 1'b1;
          cntNxt          = delayCfg;
          stateNxt        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!bothOn) begin
          stateNxt = ST_IDLE;
        end else if (cnt == '0) begin
          strobes.commit = 1'b1;
          stateNxt       = ST_ACK;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_ACK: begin
        if (!bothOn) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      dackN <= 2'b11;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      dackN <= (stateNxt == ST_ACK) ? 2'b00 : 2'b11;
    end
  end

endmodule

// File: rtl/async_wr_datapath.sv
module async_wr_datapath
  import async_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter logic [ADDR_W-IDX_W-3:0] BASE_TAG = 'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        siz,
  input  logic [WORD_W-1:0] dataIn,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic              addrHit,
  output logic [LANES-1:0]  wrLanes,
  output logic [WORD_W-1:0] peekData
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] words [DEPTH];
  logic [IDX_W-1:0]  idxQ;
  logic [LANES-1:0]  maskQ;

  assign addrHit = (addr[ADDR_W-1:IDX_W+2] == BASE_TAG);
  assign wrLanes = strobes.commit ? maskQ : '0;
  assign peekData = words[peekIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      maskQ <= '0;
    end else if (strobes.capture) begin
      idxQ  <= addr[IDX_W+1:2];
      maskQ <= laneMask(siz, addr[1:0]);
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          words[w][b*LANE_W +: LANE_W] <= '0;
        else if (wrLanes[b] && idxQ == IDX_W'(w))
          words[w][b*LANE_W +: LANE_W] <= dataIn[b*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/async_wr_target.sv
module async_wr_target
  import async_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DLY_W  = 3,
  parameter logic [ADDR_W-IDX_W-3:0] BASE_TAG = 'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rwN,
  input  logic [1:0]        siz,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       dataIn,
  input  logic [DLY_W-1:0]  delayCfg,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [31:0]       peekData,
  output logic [1:0]        dackN
);

  logic [1:0]       syncN;
  logic             asSync, dsSync;
  logic             addrHit;
  logic [LANES-1:0] wrLanes;
  ctrlStrobes_t     strobes;

  async_wr_sync #(.W(2), .INIT(2'b11)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn({asN, dsN}), .syncOut(syncN)
  );

  assign asSync = !syncN[1];
  assign dsSync = !syncN[0];

  async_wr_ctrl #(.DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .asOn(asSync), .dsOn(dsSync), .rwN(rwN),
    .addrHit(addrHit), .delayCfg(delayCfg), .strobes(strobes), .dackN(dackN)
  );

  async_wr_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_TAG(BASE_TAG)) dp_i (
    .clk(clk), .rstN(rstN), .addr(addr), .siz(siz), .dataIn(dataIn),
    .strobes(strobes), .peekIdx(peekIdx), .addrHit(addrHit),
    .wrLanes(wrLanes), .peekData(peekData)
  );

endmodule

// File: rtl/async_wr_target_chk.sv
module async_wr_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] dackN,
  input logic       asSync,
  input logic       dsSync,
  input logic [3:0] wrLanes
);

  AST_ACK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (dackN == 2'b11 || dackN == 2'b00)); // R10

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dackN == 2'b00 && asSync && dsSync) |=> dackN == 2'b00); // R5

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (dackN == 2'b00 && !(asSync && dsSync)) |=> dackN == 2'b11); // R6

  AST_WRITE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    (wrLanes != 4'b0000) |-> (asSync && dsSync)); // R8

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dackN[0]) |-> $past(wrLanes != 4'b0000)); // R4

endmodule

bind async_wr_target async_wr_target_chk chk_i (
  .clk(clk), .rstN(rstN), .dackN(dackN),
  .asSync(asSync), .dsSync(dsSync), .wrLanes(wrLanes)
);

// File: tb/async_wr_target_tb_top.sv
module async_wr_target_tb_top;

  localparam logic [3:0] TAG = 4'hA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        asN = 1'b1, dsN = 1'b1, rwN = 1'b1;
  logic [1:0]  siz = 2'b00;
  logic [7:0]  addr = '0;
  logic [31:0] dataIn = '0;
  logic [2:0]  delayCfg = '0;
  logic [1:0]  peekIdx = '0;
  logic [31:0] peekData;
  logic [1:0]  dackN;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model [4];

  always #10 clk = ~clk;

  async_wr_target dut_i (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .rwN(rwN), .siz(siz),
    .addr(addr), .dataIn(dataIn), .delayCfg(delayCfg), .peekIdx(peekIdx),
    .peekData(peekData), .dackN(dackN)
  );

  typedef struct packed {
    logic [1:0]  idx;
    logic [1:0]  off;
    logic [1:0]  siz;
    logic [2:0]  dly;
    logic [1:0]  rel;   // 0 both, 1 address strobe first, 2 data strobe first
    logic [31:0] data;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 2'd0, 2'b00, 3'd0, 2'd0, 32'h11223344},
    '{2'd1, 2'd2, 2'b01, 3'd1, 2'd1, 32'hAABBCCDD},
    '{2'd1, 2'd0, 2'b10, 3'd2, 2'd2, 32'h55667788},
    '{2'd2, 2'd1, 2'b11, 3'd3, 2'd0, 32'hDEADBEEF},
    '{2'd2, 2'd3, 2'b10, 3'd4, 2'd1, 32'h0102A5A5},
    '{2'd3, 2'd2, 2'b11, 3'd5, 2'd2, 32'hCAFEF00D},
    '{2'd3, 2'd1, 2'b00, 3'd6, 2'd0, 32'h99887766},
    '{2'd0, 2'd3, 2'b01, 3'd7, 2'd1, 32'h123456F1},
    '{2'd0, 2'd1, 2'b01, 3'd0, 2'd2, 32'h00E70000},
    '{2'd2, 2'd0, 2'b01, 3'd2, 2'd0, 32'h7F000000}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [1:0] idx, input logic [1:0] off,
                            input logic [1:0] sz, input logic [31:0] d);
    int first = int'(off);
    int last  = first + ((sz == 2'b00) ? 4 : int'(sz)) - 1;
    if (last > 3) last = 3;
    for (int k = first; k <= last; k++)
      model[idx][31-8*k -: 8] = d[31-8*k -: 8];
  endtask

  task automatic checkWord(input logic [1:0] idx, input string tag);
    peekIdx = idx;
    #1;
    check(peekData === model[idx], tag, peekData, model[idx]);
  endtask

  task automatic checkAllWords(input string tag);
    for (int i = 0; i < 4; i++) checkWord(2'(i), tag);
  endtask

  // full write handshake, measures latency to acknowledge and to release
  task automatic busWrite(input vec_t v);
    int lat = 0;
    int rl = 0;
    bit legal = 1'b1;
    @(negedge clk);
    addr = {TAG, v.idx, v.off}; siz = v.siz; rwN = 1'b0;
    dataIn = v.data; delayCfg = v.dly; asN = 1'b0;
    @(negedge clk);
    dsN = 1'b0;
    while (dackN !== 2'b00 && lat < 30) begin
      @(negedge clk); lat++;
      if (dackN !== 2'b00 && dackN !== 2'b11) legal = 1'b0;
    end
    check(lat == int'(v.dly) + 4, "R4 ack latency", 32'(lat), 32'(int'(v.dly) + 4));
    repeat (3) @(negedge clk);
    check(dackN === 2'b00, "R5 ack held", 32'(dackN), 32'h0);
    case (v.rel)
      2'd1:    asN = 1'b1;
      2'd2:    dsN = 1'b1;
      default: begin asN = 1'b1; dsN = 1'b1; end
    endcase
    while (dackN !== 2'b11 && rl < 10) begin
      @(negedge clk); rl++;
      if (dackN !== 2'b00 && dackN !== 2'b11) legal = 1'b0;
    end
    check(rl == 3, "R6 release latency", 32'(rl), 32'd3);
    check(legal, "R10 ack encoding", 32'(legal), 32'd1);
    asN = 1'b1; dsN = 1'b1; rwN = 1'b1;
    repeat (3) @(negedge clk);
    modelWrite(v.idx, v.off, v.siz, v.data);
    checkWord(v.idx, "R2 R3 stored word");
  endtask

  // cycle expected to get no acknowledge; watches for cycles with strobes held
  task automatic noAckCycle(input logic [7:0] a, input logic rw, input int hold,
                            input string tag);
    bit seen = 1'b0;
    @(negedge clk);
    addr = a; siz = 2'b00; rwN = rw; dataIn = 32'hFFFFFFFF; asN = 1'b0;
    @(negedge clk);
    dsN = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (dackN !== 2'b11) seen = 1'b1;
    end
    asN = 1'b1; dsN = 1'b1; rwN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dackN !== 2'b11) seen = 1'b1;
    end
    check(!seen, {tag, " no ack"}, 32'(seen), 32'd0);
    checkAllWords({tag, " storage unchanged"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(dackN === 2'b11, "R1 ack in reset", 32'(dackN), 32'h3);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(dackN === 2'b11, "R1 ack after reset", 32'(dackN), 32'h3);
    checkAllWords("R1 words zero");

    for (int n = 0; n < NVEC; n++) busWrite(VEC[n]);

    // read cycle ignored
    noAckCycle({TAG, 2'd1, 2'd0}, 1'b1, 15, "R7 read");
    // base tag mismatch ignored
    noAckCycle({4'h5, 2'd2, 2'd0}, 1'b0, 15, "R9 tag mismatch");
    // strobes dropped during a long delay: aborted
    delayCfg = 3'd7;
    noAckCycle({TAG, 2'd3, 2'd0}, 1'b0, 3, "R8 abort");
    // after the abort, a normal write still works
    busWrite('{2'd3, 2'd0, 2'b10, 3'd1, 2'd0, 32'h4242ABCD});

    // reset in the middle of an acknowledge
    @(negedge clk);
    addr = {TAG, 2'd1, 2'd0}; siz = 2'b00; rwN = 1'b0; dataIn = 32'h13572468;
    delayCfg = 3'd0; asN = 1'b0;
    @(negedge clk); dsN = 1'b0;
    repeat (6) @(negedge clk);
    check(dackN === 2'b00, "R4 ack before reset", 32'(dackN), 32'h0);
    rstN = 1'b0;
    #1;
    check(dackN === 2'b11, "R1 ack cleared by reset", 32'(dackN), 32'h3);
    for (int i = 0; i < 4; i++) model[i] = '0;
    checkAllWords("R1 words cleared");
    asN = 1'b1; dsN = 1'b1; rwN = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(dackN === 2'b11, "R1 idle after reset", 32'(dackN), 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule